// File: doc/BRIEF.md
# Glitch-Free Delay-Line Switching Sequencer

This block drives the select pair of each stage of a 64-stage NAND-gate delay line. Each stage has an S bit and a T bit, and each stage is in one of three states:

| State | S | T | Meaning |
|-------|---|---|---------|
| pass | 0 | 1 | the edge travels on to the next stage |
| turn | 1 | 1 | the stage returns the edge |
| post-turn | 1 | 0 | the stage blocks the upper path |

A client sends a new delay code. The sequencer then walks the line from its present code to the new code in three ordered, single-cycle phases:

1. The stage that was in post-turn goes back to turn.
2. The boundary between pass and turn moves to the new code. No stage is in post-turn while this happens.
3. The stage just above the new turning stage enters post-turn.

Every S and T bit comes straight from a flip-flop. The line therefore never sees a hazard on its selects, and it never passes through a state that can glitch.

The code input is a valid/ready channel. A code is taken on a clock edge where `code_valid` and `code_ready` are both high. `code_ready` is low for exactly the three cycles of a transition. While it is low, the offer is neither taken nor remembered. The client may keep `code_valid` high with the same code or change the code, and the sequencer samples it again once ready returns. A code equal to the present code is taken, but it leaves the line as it is and starts no transition. `seq_busy` shows that a transition is in progress.

Top module: `dcdl_switch_seq`

## Requirements
- R1: After reset the line holds code 0. Every S bit is 1, every T bit is 1 except T[1], which is 0. `seq_busy` is 0 and `code_ready` is 1.
- R2: When idle at code c (0..63), stages 0..c-1 are in pass, stage c is in turn, stage c+1 (if c<63) is in post-turn, and all higher stages are in turn.
- R3: T[0] is 1 at all times.
- R4: One cycle after a code is taken, the old post-turn stage is back in turn, so all T bits are 1. The S bits are unchanged.
- R5: In the second phase the S bits change to the pattern of the new code (S[i]=1 exactly when i is at least the new code). All T bits stay 1.
- R6: In the third phase T[h+1] goes to 0 for the new code h. When h is 63, all T bits stay 1.
- R7: `seq_busy` is high for exactly three cycles, starting one cycle after the taking edge. `code_ready` equals the inverse of `seq_busy`.
- R8: A valid code offered while busy is not taken and does not change the transition in progress.
- R9: A taken code equal to the present code changes no S or T bit and leaves `seq_busy` low.
- R10: While idle, S and T hold their values. A code taken on a given edge changes no select bit on that edge.
- R11: With a code wider than the line needs, codes above the top stage index are clamped to that index. At the default widths every 6-bit code is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| code_valid | input | 1 | a new delay code is offered |
| code_ready | output | 1 | sequencer can take a code (not busy) |
| code_data | input | 6 | offered delay code |
| sel_s | output | 64 | S bit of each stage, bit i for stage i |
| sel_t | output | 64 | T bit of each stage, bit i for stage i |
| seq_busy | output | 1 | a three-phase transition is in progress |

## Verification
The end of a transition and the taking of the next code can fall in the same cycle. When phase three completes, ready rises, and a code already held valid is taken on the very next edge. The bench provokes this by keeping `code_valid` high with a second code for the whole first transition. The scoreboard then expects the second transition's phases to follow the first without a gap, and with the old code taken from the finished first transition. A code offered during the busy cycles that is then withdrawn is judged by the final state, which must be the first target.

// File: rtl/dcdl_seq_pkg.sv
package dcdl_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RELEASE = 2'd1,
    PH_SHIFT   = 2'd2,
    PH_PLACE   = 2'd3
  } seq_ph_e;

endpackage

// File: rtl/dcdl_thermo_dec.sv
// Stage i selects turn-or-above (S=1) when i >= code.
module dcdl_thermo_dec #(
  parameter int N_ELEM = 64,
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [N_ELEM-1:0] at_or_above
);
  for (genvar i = 0; i < N_ELEM; i++) begin : g_bit
    assign at_or_above[i] = (32'(code) <= i);
  end
endmodule

// File: rtl/dcdl_post_dec.sv
// One-hot mark of the stage directly above the turning stage.
module dcdl_post_dec #(
  parameter int N_ELEM = 64,
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [N_ELEM-1:0] post_mark
);
  for (genvar i = 0; i < N_ELEM; i++) begin : g_bit
    assign post_mark[i] = ((32'(code) + 32'd1) == i);
  end
endmodule

// File: rtl/dcdl_seq_fsm.sv
module dcdl_seq_fsm
  import dcdl_seq_pkg::*;
#(
  parameter int N_ELEM = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_data,
  output logic              code_ready,
  output logic              busy,
  output seq_ph_e           phase,
  output logic [CODE_W-1:0] code_old,
  output logic [CODE_W-1:0] code_new
);
  localparam int  MAX_CODE = N_ELEM - 1;
  localparam bit  NEED_SAT = ((2 ** CODE_W) > N_ELEM);

  logic [CODE_W-1:0] req_code;
  logic [CODE_W-1:0] cur_q;
  logic [CODE_W-1:0] nxt_q;
  seq_ph_e           ph_q;
  logic              busy_q;
  logic              take_new;

  // R11: clamp codes beyond the top stage
  if (NEED_SAT) begin : g_sat
    assign req_code = (code_data > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_data;
  end else begin : g_nosat
    assign req_code = code_data;
  end

  assign take_new = code_valid && !busy_q && (req_code != cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      busy_q <= 1'b0;
      cur_q  <= '0;
      nxt_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (take_new) begin
            nxt_q  <= req_code;
            ph_q   <= PH_RELEASE;
            busy_q <= 1'b1;
          end
        end
        PH_RELEASE: ph_q <= PH_SHIFT;
        PH_SHIFT:   ph_q <= PH_PLACE;
        PH_PLACE: begin
          cur_q  <= nxt_q;
          ph_q   <= PH_IDLE;
          busy_q <= 1'b0;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign code_ready = !busy_q;
  assign busy       = busy_q;
  assign phase      = ph_q;
  assign code_old   = cur_q;
  assign code_new   = nxt_q;
endmodule

// File: rtl/dcdl_elem_drv.sv
// Registered S/T pair of one stage; reset value matches code 0.
module dcdl_elem_drv
  import dcdl_seq_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  seq_ph_e phase,
  input  logic    s_next,
  input  logic    post_old,
  input  logic    post_new,
  output logic    s_q,
  output logic    t_q
);
  localparam logic T_RST = (IDX != 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b1;
      t_q <= T_RST;
    end else begin
      unique case (phase)
        PH_RELEASE: if (post_old) t_q <= 1'b1;
        PH_SHIFT:   s_q <= s_next;
        PH_PLACE:   if (post_new) t_q <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcdl_switch_seq.sv
module dcdl_switch_seq
  import dcdl_seq_pkg::*;
#(
  parameter int N_ELEM = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  output logic [N_ELEM-1:0] sel_s,
  output logic [N_ELEM-1:0] sel_t,
  output logic              seq_busy
);
  seq_ph_e           phase;
  logic [CODE_W-1:0] code_old;
  logic [CODE_W-1:0] code_new;
  logic [N_ELEM-1:0] s_target;
  logic [N_ELEM-1:0] mark_old;
  logic [N_ELEM-1:0] mark_new;

  dcdl_seq_fsm #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_data  (code_data),
    .code_ready (code_ready),
    .busy       (seq_busy),
    .phase      (phase),
    .code_old   (code_old),
    .code_new   (code_new)
  );

  dcdl_thermo_dec #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_thermo_new (
    .code        (code_new),
    .at_or_above (s_target)
  );

  dcdl_post_dec #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_post_old (
    .code      (code_old),
    .post_mark (mark_old)
  );

  dcdl_post_dec #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_post_new (
    .code      (code_new),
    .post_mark (mark_new)
  );

  // Stage 0 never receives a post-turn mark, so its T flop holds 1 (R3).
  for (genvar i = 0; i < N_ELEM; i++) begin : g_stage
    dcdl_elem_drv #(.IDX(i)) u_elem (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .s_next   (s_target[i]),
      .post_old (mark_old[i]),
      .post_new (mark_new[i]),
      .s_q      (sel_s[i]),
      .t_q      (sel_t[i])
    );
  end
endmodule

// File: rtl/dcdl_switch_seq_chk.sv
module dcdl_switch_seq_chk #(
  parameter int N_ELEM = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              code_valid,
  input logic              code_ready,
  input logic [N_ELEM-1:0] sel_s,
  input logic [N_ELEM-1:0] sel_t,
  input logic              seq_busy
);
  a_r3_t0_high: assert property (@(posedge clk) disable iff (!rst_n)
    sel_t[0]);

  a_r2_single_post: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_t) <= 1);

  a_r2_s_thermo: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s[N_ELEM-1] && ((sel_s[N_ELEM-2:0] & ~sel_s[N_ELEM-1:1]) == '0));

  a_r7_busy_three: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |=> seq_busy ##1 seq_busy ##1 !seq_busy);

  a_r4_release_keeps_s: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |=> ($stable(sel_s) && (&sel_t)));

  a_r5_s_moves_t_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_s) |-> (&sel_t));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |=> ($stable(sel_s) && $stable(sel_t)));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && code_valid) |=> $stable(sel_s) || (&sel_t));
endmodule

bind dcdl_switch_seq dcdl_switch_seq_chk #(.N_ELEM(N_ELEM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_valid (code_valid),
  .code_ready (code_ready),
  .sel_s      (sel_s),
  .sel_t      (sel_t),
  .seq_busy   (seq_busy)
);

// File: tb/dcdl_switch_seq_bench.sv
module dcdl_switch_seq_bench;
  localparam int N  = 64;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          code_valid;
  logic          code_ready;
  logic [CW-1:0] code_data;
  logic [N-1:0]  sel_s;
  logic [N-1:0]  sel_t;
  logic          seq_busy;

  always #10 clk = ~clk;  // 50 MHz

  dcdl_switch_seq #(.N_ELEM(N), .CODE_W(CW)) u_dcdl_switch_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_data  (code_data),
    .sel_s      (sel_s),
    .sel_t      (sel_t),
    .seq_busy   (seq_busy)
  );

  typedef struct {
    logic [N-1:0] s;
    logic [N-1:0] t;
    logic         b;
    string        req;
  } exp_item_t;

  exp_item_t sbq[$];
  exp_item_t mon_it;
  int  checks = 0;
  int  errors = 0;
  int  cur    = 0;
  bit  done   = 0;

  function automatic logic [N-1:0] exp_s(int c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (i >= c);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_t(int c);
    logic [N-1:0] r;
    r = '1;
    if (c < N - 1) r[c+1] = 1'b0;
    return r;
  endfunction

  task automatic compare(string req, logic [N-1:0] s, logic [N-1:0] t, logic b);
    checks++;
    if (sel_s !== s || sel_t !== t || seq_busy !== b || code_ready !== !b) begin
      errors++;
      $display("FAIL %s: s=%h t=%h busy=%b ready=%b expected s=%h t=%h busy=%b ready=%b",
               req, sel_s, sel_t, seq_busy, code_ready, s, t, b, !b);
    end
  endtask

  task automatic push(logic [N-1:0] s, logic [N-1:0] t, logic b, string req);
    exp_item_t it;
    it.s = s; it.t = t; it.b = b; it.req = req;
    sbq.push_back(it);
  endtask

  // Expected view after each of the four edges following a take.
  task automatic push_trans(int k, int h);
    if (k == h) begin
      push(exp_s(k), exp_t(k), 1'b0, "R9 same code");
    end else begin
      push(exp_s(k), exp_t(k), 1'b1, "R7/R10 take edge");
      push(exp_s(k), '1,       1'b1, "R4 release");
      push(exp_s(h), '1,       1'b1, "R5 shift");
      push(exp_s(h), exp_t(h), 1'b0, "R6 place");
    end
  endtask

  // Monitor: pops one expected item per edge, samples after the edge settles.
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      mon_it = sbq.pop_front();
      compare(mon_it.req, mon_it.s, mon_it.t, mon_it.b);
    end
  end

  // mode 0: plain; mode 1: junk offer during busy (R8); mode 2: hold valid with next code
  task automatic do_load(int h, int mode, int other);
    @(negedge clk);
    code_valid = 1'b1;
    code_data  = CW'(h);
    push_trans(cur, h);
    @(posedge clk); #1;
    if (mode == 0) code_valid = 1'b0;
    else           code_data  = CW'(other);
    repeat (3) @(posedge clk);
    #1;
    if (cur != h) cur = h;
    if (mode == 1) code_valid = 1'b0;
    if (mode == 2) begin
      push_trans(cur, other);
      @(posedge clk); #1;
      code_valid = 1'b0;
      repeat (3) @(posedge clk);
      cur = other;
    end
    while (sbq.size() > 0) @(posedge clk);
    #5;
  endtask

  task automatic check_state(string req);
    compare(req, exp_s(cur), exp_t(cur), 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    code_valid = 1'b0;
    code_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    do_load(5, 0, 0);   check_state("R2 code 5");
    do_load(63, 0, 0);  check_state("R2 code 63, R6 no post-turn");
    do_load(0, 0, 0);   check_state("R2 code 0");
    checks++;
    if (sel_t[0] !== 1'b1) begin
      errors++;
      $display("FAIL R3: t0=%b expected 1", sel_t[0]);
    end
    do_load(1, 0, 0);   check_state("R2 code 1");
    do_load(0, 0, 0);   check_state("R2 back to 0");
    do_load(30, 1, 12); check_state("R8 busy offer ignored");
    do_load(30, 0, 0);  check_state("R9 same code");
    do_load(10, 2, 40); check_state("R7 back-to-back take");
    do_load(62, 0, 0);  check_state("R2 code 62");
    do_load(63, 0, 0);  check_state("R6 top code");
    repeat (5) @(posedge clk);
    #3;
    check_state("R10 idle hold");
    do_load(33, 0, 0);  check_state("R11 mid code");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule